// File: doc/BRIEF.md
# Selection-Steered Bidirectional Port Bridge

This block turns a complete 8-bit port into a two-way buffer. On one side is a local multiplexed address/data bus. On the other side is an external shared resource. The port's direction is not set by a register. Three decoded range selects and the bus strobes choose it again on every clock. One select sends the address phase out to the port. One sends write data out to the port. One returns the port's value to the local bus as read data. Logic elsewhere builds the selects, and they arrive here as plain inputs. The address select is expected to stay steady for the whole time the address latch strobe is high.

All inputs are sampled on the rising clock edge. A five-state machine holds the decision: ST_IDLE, ST_ADDR, ST_WDATA, ST_RDATA and ST_CLASH. The transitions are evaluated in priority order, and any state can move to any other on the next edge:
- Enable low leads to ST_IDLE.
- Read and write strobes both high lead to ST_CLASH.
- Address select with latch strobe leads to ST_ADDR.
- Write select with write strobe leads to ST_WDATA.
- Read select with read strobe leads to ST_RDATA.
- Anything else leads to ST_IDLE.

Outputs and forwarded data are registered, so the pads follow the inputs one clock later.

Top module: `bidir_track_bridge`

## Requirements
- R1: After reset, every enable bit on both sides is 0 and `clash` is 0.
- R2: The bits of `port_oe` are always either all 0 or all 1. The bits of `lbus_oe` follow the same rule.
- R3: If `mode_en`, `sel_addr` and `ale` are high at a rising edge, with no read/write clash, then after that edge `port_oe` is all ones and `port_out` equals the `lbus_in` sampled at that edge.
- R4: If `sel_wr` and `wr` are high at an edge, with no address pass and no clash, then after that edge `port_oe` is all ones and `port_out` equals the sampled `lbus_in`.
- R5: If `sel_rd` and `rd` are high at an edge, with no address pass or write pass and no clash, then after that edge `lbus_oe` is all ones and `lbus_out` equals the sampled `port_in`.
- R6: If no pass condition holds, both sides are tri-stated after the edge (enables 0, values 0).
- R7: If `mode_en` is high and `rd` and `wr` are both high, then after the edge nothing is driven and `clash` is 1. `clash` drops once that condition is gone.
- R8: If `mode_en` is low, then after the edge nothing is driven and `clash` is 0, whatever the other inputs are.
- R9: The port side and the local-bus side are never driven in the same cycle.
- R10: Priority is clash first, then address pass, then write pass, then read pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Gates all bridging |
| sel_addr | input | 1 | Decoded select: pass address to port |
| sel_wr | input | 1 | Decoded select: pass write data to port |
| sel_rd | input | 1 | Decoded select: pass port data to local bus |
| ale | input | 1 | Address latch strobe, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| lbus_in | input | 8 | Local bus pad input |
| port_in | input | 8 | Port pad input |
| port_oe | output | 8 | Port pad enables |
| port_out | output | 8 | Port pad drive values |
| lbus_oe | output | 8 | Local bus pad enables |
| lbus_out | output | 8 | Local bus pad drive values |
| clash | output | 1 | Read and write strobes seen together |

## Verification
The bench raises several pass conditions at once. A design with the wrong priority would then drive the wrong side or forward the wrong data. Read and write strobes are asserted together under every select. A faulty design would drive a pad while `clash` is set, or would leave `clash` set after the strobes separate. Patterns are also applied with the enable low and all selects high; a bridge that ignored the gate would drive pads there. Back-to-back read and write cycles expose a design that drives both sides at once or that forwards data sampled on the wrong edge.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_CLASH = 3'd4
    } bridge_state_e;

endpackage

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic sel_addr,
    input  logic sel_wr,
    input  logic sel_rd,
    input  logic ale,
    input  logic rd,
    input  logic wr,
    output logic cap_port,
    output logic cap_lbus,
    output logic drive_port,
    output logic drive_lbus,
    output logic clash
);

    bridge_state_e state_q, state_d;

    // next-state decision, priority ordered (R10)
    always_comb begin
        if (!mode_en)
            state_d = ST_IDLE;
        else if (rd && wr)
            state_d = ST_CLASH;
        else if (sel_addr && ale)
            state_d = ST_ADDR;
        else if (sel_wr && wr)
            state_d = ST_WDATA;
        else if (sel_rd && rd)
            state_d = ST_RDATA;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // capture strobes for the data lanes, taken from the next state
    always_comb begin
        cap_port = 1'b0;
        cap_lbus = 1'b0;
        unique case (state_d)
            ST_ADDR, ST_WDATA: cap_port = 1'b1;
            ST_RDATA:          cap_lbus = 1'b1;
            ST_IDLE, ST_CLASH: ;
            default:           ;
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        drive_port = 1'b0;
        drive_lbus = 1'b0;
        clash      = 1'b0;
        unique case (state_q)
            ST_ADDR, ST_WDATA: drive_port = 1'b1;
            ST_RDATA:          drive_lbus = 1'b1;
            ST_CLASH:          clash      = 1'b1;
            ST_IDLE:           ;
            default:           ;
        endcase
    end

    // R9: one direction at a time
    p_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_port && drive_lbus));

    // R7: a clash state never drives
    p_clash_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> (!drive_port && !drive_lbus));

endmodule

// File: rtl/bridge_lane.sv
module bridge_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_port,
    input  logic cap_lbus,
    input  logic drive_port,
    input  logic drive_lbus,
    input  logic lbus_bit,
    input  logic port_bit,
    output logic port_oe_bit,
    output logic port_out_bit,
    output logic lbus_oe_bit,
    output logic lbus_out_bit
);

    logic to_port_q;
    logic to_lbus_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_port_q <= 1'b0;
            to_lbus_q <= 1'b0;
        end else begin
            if (cap_port) to_port_q <= lbus_bit;
            if (cap_lbus) to_lbus_q <= port_bit;
        end
    end

    assign port_oe_bit  = drive_port;
    assign port_out_bit = drive_port & to_port_q;
    assign lbus_oe_bit  = drive_lbus;
    assign lbus_out_bit = drive_lbus & to_lbus_q;

endmodule

// File: rtl/bidir_track_bridge.sv
module bidir_track_bridge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_en,
    input  logic         sel_addr,
    input  logic         sel_wr,
    input  logic         sel_rd,
    input  logic         ale,
    input  logic         rd,
    input  logic         wr,
    input  logic [W-1:0] lbus_in,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] port_oe,
    output logic [W-1:0] port_out,
    output logic [W-1:0] lbus_oe,
    output logic [W-1:0] lbus_out,
    output logic         clash
);

    localparam logic [W-1:0] ALL_ON = {W{1'b1}};

    logic cap_port, cap_lbus, drive_port, drive_lbus;

    bridge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .sel_addr  (sel_addr),
        .sel_wr    (sel_wr),
        .sel_rd    (sel_rd),
        .ale       (ale),
        .rd        (rd),
        .wr        (wr),
        .cap_port  (cap_port),
        .cap_lbus  (cap_lbus),
        .drive_port(drive_port),
        .drive_lbus(drive_lbus),
        .clash     (clash)
    );

    for (genvar i = 0; i < W; i++) begin : g_lane
        bridge_lane u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .cap_port    (cap_port),
            .cap_lbus    (cap_lbus),
            .drive_port  (drive_port),
            .drive_lbus  (drive_lbus),
            .lbus_bit    (lbus_in[i]),
            .port_bit    (port_in[i]),
            .port_oe_bit (port_oe[i]),
            .port_out_bit(port_out[i]),
            .lbus_oe_bit (lbus_oe[i]),
            .lbus_out_bit(lbus_out[i])
        );
    end

    // R2: the whole port switches together
    p_whole_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe == '0 || port_oe == ALL_ON) && (lbus_oe == '0 || lbus_oe == ALL_ON));

    // R8: gate low means silence next cycle
    p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (port_oe == '0 && lbus_oe == '0 && !clash));

    // R7: simultaneous strobes flag a clash
    p_clash_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && rd && wr) |=> (clash && port_oe == '0 && lbus_oe == '0));

    // R3: address pass forwards the sampled local bus
    p_addr_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && sel_addr && ale && !(rd && wr)) |=>
            (port_oe == ALL_ON && port_out == $past(lbus_in)));

    // R5: read pass returns the sampled port
    p_read_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && sel_rd && rd && !wr && !(sel_addr && ale)) |=>
            (lbus_oe == ALL_ON && lbus_out == $past(port_in)));

endmodule

// File: tb/bidir_track_bridge_tb.sv
`timescale 1ns/1ps
module bidir_track_bridge_tb_top;

    localparam int W = 8;

    typedef struct {
        logic         p_on;
        logic [W-1:0] p_val;
        logic         l_on;
        logic [W-1:0] l_val;
        logic         clash;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, sel_addr = 1'b0, sel_wr = 1'b0, sel_rd = 1'b0;
    logic ale = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [W-1:0] lbus_in = '0, port_in = '0;
    logic [W-1:0] port_oe, port_out, lbus_oe, lbus_out;
    logic clash;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    bidir_track_bridge #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .sel_addr(sel_addr), .sel_wr(sel_wr), .sel_rd(sel_rd),
        .ale(ale), .rd(rd), .wr(wr),
        .lbus_in(lbus_in), .port_in(port_in),
        .port_oe(port_oe), .port_out(port_out),
        .lbus_oe(lbus_oe), .lbus_out(lbus_out), .clash(clash)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // driver: applies one pattern and predicts the result from the requirements
    task automatic apply(input logic me, input logic sa, input logic sw, input logic sr,
                         input logic a, input logic r, input logic w,
                         input logic [W-1:0] lb, input logic [W-1:0] pi, input string tag);
        exp_t e;
        @(negedge clk);
        mode_en = me; sel_addr = sa; sel_wr = sw; sel_rd = sr;
        ale = a; rd = r; wr = w; lbus_in = lb; port_in = pi;
        e.p_on = 0; e.p_val = '0; e.l_on = 0; e.l_val = '0; e.clash = 0; e.tag = tag;
        if (!me) ;
        else if (r && w) e.clash = 1;
        else if (sa && a) begin e.p_on = 1; e.p_val = lb; end
        else if (sw && w) begin e.p_on = 1; e.p_val = lb; end
        else if (sr && r) begin e.l_on = 1; e.l_val = pi; end
        sb_q.push_back(e);
    endtask

    // monitor: compares after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " port_oe"},  port_oe,  {W{e.p_on}});
            check({e.tag, " port_out"}, port_out, e.p_val);
            check({e.tag, " lbus_oe"},  lbus_oe,  {W{e.l_on}});
            check({e.tag, " lbus_out"}, lbus_out, e.l_val);
            check({e.tag, " clash"},    {{(W-1){1'b0}}, clash}, {{(W-1){1'b0}}, e.clash});
            check("R9 single side", {{(W-1){1'b0}}, (|port_oe) & (|lbus_oe)}, '0);
            check("R2 whole port",
                  {{(W-1){1'b0}}, (port_oe != '0 && port_oe != '1)}, '0);
        end
    end

    initial begin
        #400000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset port_oe", port_oe, '0);
        check("R1 reset lbus_oe", lbus_oe, '0);
        check("R1 reset clash", {{(W-1){1'b0}}, clash}, '0);
        rst_n = 1'b1;
        //     me sa sw sr a  r  w  lbus   port
        apply(1, 0, 0, 0, 0, 0, 0, 8'h11, 8'h22, "R6 idle");
        apply(1, 1, 0, 0, 1, 0, 0, 8'hA5, 8'h3C, "R3 addr pass");
        apply(1, 1, 0, 0, 0, 0, 0, 8'h5A, 8'h3C, "R6 sel without ale");
        apply(1, 0, 1, 0, 0, 0, 1, 8'hC3, 8'h00, "R4 write pass");
        apply(1, 0, 0, 1, 0, 1, 0, 8'h00, 8'h96, "R5 read pass");
        apply(1, 0, 1, 0, 0, 0, 1, 8'h7E, 8'h81, "R9 read then write");
        apply(1, 0, 0, 1, 0, 1, 0, 8'h7E, 8'h18, "R5 write then read");
        apply(1, 0, 1, 0, 0, 1, 0, 8'hFF, 8'hFF, "R6 write sel on read");
        apply(1, 0, 0, 1, 0, 0, 1, 8'hFF, 8'hFF, "R6 read sel on write");
        apply(1, 1, 1, 1, 1, 1, 1, 8'h44, 8'h55, "R7 clash all sels");
        apply(1, 0, 0, 1, 0, 1, 1, 8'h44, 8'h55, "R7 clash read sel");
        apply(1, 0, 0, 0, 0, 0, 0, 8'h44, 8'h55, "R7 clash clears");
        apply(1, 1, 1, 0, 1, 0, 1, 8'h0F, 8'hF0, "R10 addr over write");
        apply(1, 1, 0, 1, 1, 1, 0, 8'h3A, 8'hC5, "R10 addr over read");
        apply(1, 0, 1, 1, 0, 1, 1, 8'h3A, 8'hC5, "R10 clash over pass");
        apply(0, 1, 1, 1, 1, 0, 1, 8'hAA, 8'hBB, "R8 gate off write");
        apply(0, 0, 0, 1, 0, 1, 0, 8'hAA, 8'hBB, "R8 gate off read");
        apply(0, 1, 1, 1, 1, 1, 1, 8'hAA, 8'hBB, "R8 gate off clash");
        apply(1, 1, 0, 0, 1, 0, 0, 8'h01, 8'h00, "R3 addr low bit");
        apply(1, 1, 0, 0, 1, 0, 0, 8'h80, 8'h00, "R3 addr high bit");
        apply(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R6 final idle");
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule